// File: doc/BRIEF.md
# Receive Mailbox Bank with Lowest-Free Allocation

This block sits behind a CAN receiver that has already decoded a frame (identifier, extended flag, remote-request flag, length code and eight payload bytes) and parks each frame in one of a bank of receive mailboxes. Each mailbox carries a small mode code set by software. A new frame always lands in the lowest-numbered mailbox that is set up for reception and currently empty. Once filled, a mailbox keeps its frame and turns away further frames until software re-arms it. Re-arming takes a bitmask, so several mailboxes can be released in one write.

A mailbox set to the overwrite flavour of receive mode is the last resort. When every ordinary mailbox is full, it takes the frame even while it is occupied, replaces its contents, and raises a lost-message flag. If there is no free mailbox and no overwrite mailbox, the frame is dropped and a sticky overrun flag is raised. Ready flags appear as a vector indexed by mailbox number, and a mask over the same vector drives one interrupt line. Software reads each mailbox's mode, identifier, status and payload words through a combinational read port. All identifiers are accepted.

Top module: `rxmb_bank`

## Requirements
- R1: A frame is written into the lowest-indexed mailbox whose mode is receive (code 1) or receive-with-overwrite (code 2) and whose ready flag is clear. The ready flag is visible on the cycle after the frame is presented.
- R2: A mailbox with its ready flag set keeps its stored frame and takes no new frame in receive mode. A ready flag only rises on the cycle after a frame was presented.
- R3: A cycle with the re-arm strobe clears the ready flag and the lost flag of every mailbox whose bit is 1 in the re-arm mask. Any number of bits may be set in one write.
- R4: Mode codes are 0 disabled, 1 receive, 2 receive with overwrite, 3 transmit. A mailbox in mode 0 or 3 never receives. The mode reads back in bits 26:24 of the mode word (read select 0).
- R5: When no mailbox is free, the lowest full mailbox in mode 2 takes the frame, replaces its contents and sets the lost flag (bit 24 of the status word). A mode-2 mailbox that is empty takes a frame like any other, with the lost flag left clear.
- R6: The identifier word (read select 1) holds a standard 11-bit identifier in bits 28:18. It holds an extended 29-bit identifier in bits 28:0 with bit 29 set. All other bits are zero.
- R7: The status word (read select 2) carries the length code in bits 19:16, the RTR flag at bit 20, the ready flag at bit 23 and the lost flag at bit 24. All other bits are zero.
- R8: Bit i of `ready_vec` is the ready flag of mailbox i. `irq` is high exactly when some mailbox is ready and its `irq_mask` bit is 1.
- R9: The payload reads back as two words. Select 3 returns bytes 0-3 and select 4 returns bytes 4-7, with byte 0 in bits 7:0.
- R10: A frame that finds no free mailbox and no mode-2 mailbox is dropped and leaves every mailbox unchanged. It sets `overrun`, which stays set until reset.
- R11: After reset every mailbox is in mode 0 with ready and lost clear, and `overrun` and `irq` are low.
- R12: If a frame is captured into a mailbox in the same cycle that the re-arm mask names it, the capture wins and the mailbox ends up ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frm_valid | input | 1 | A decoded frame is presented this cycle |
| frm_ext | input | 1 | Frame uses a 29-bit identifier |
| frm_id | input | 29 | Identifier; a standard identifier sits in bits 10:0 |
| frm_rtr | input | 1 | Remote-request flag |
| frm_dlc | input | 4 | Length code |
| frm_data | input | 64 | Payload, byte k in bits 8k+7:8k |
| cfg_we | input | 1 | Write the mode of one mailbox |
| cfg_mb | input | IDXW | Mailbox whose mode is written |
| cfg_mode | input | 3 | New mode code |
| rearm_we | input | 1 | Re-arm strobe |
| rearm_mask | input | NUM_MB | Mailboxes to re-arm |
| irq_mask | input | NUM_MB | Interrupt enable per mailbox |
| rd_mb | input | IDXW | Mailbox to read |
| rd_sel | input | 3 | Word to read: 0 mode, 1 id, 2 status, 3 data low, 4 data high |
| rd_data | output | 32 | Read-back word |
| ready_vec | output | NUM_MB | Ready flag per mailbox |
| irq | output | 1 | Masked OR of the ready flags |
| overrun | output | 1 | Sticky dropped-frame flag |

## Verification
The bench fills the bank in order and checks that a disabled mailbox at index 0 and a transmit mailbox in the middle are skipped. A design that scanned from the top, or that allowed mode 3 to receive, would put frames in the wrong slots. It then forces an overwrite on the last mailbox and checks both the replaced contents and the lost flag. An allocator that dropped the frame, or kept the old one, would fail here. Later steps re-arm a gap and check that the next frame falls into it rather than at the end. They also remove the overwrite mailbox and check that a frame is dropped, that the overrun flag stays set, and that no mailbox changes. A frame and a re-arm of the same mailbox in one cycle check that the capture is not lost to the clear.

// File: rtl/rxmb_pkg.sv
// Shared types for the receive mailbox bank.
// Assumes a frame arrives fully decoded in one cycle.
package rxmb_pkg;

    typedef enum logic [2:0] {
        MB_OFF    = 3'd0,
        MB_RX     = 3'd1,
        MB_RX_OVR = 3'd2,
        MB_TX     = 3'd3
    } mb_mode_e;

    typedef struct packed {
        logic        ext;
        logic [28:0] id;
        logic        rtr;
        logic [3:0]  dlc;
        logic [63:0] data;
    } rx_frame_t;

    localparam logic [2:0] SEL_MODE = 3'd0;
    localparam logic [2:0] SEL_ID   = 3'd1;
    localparam logic [2:0] SEL_STAT = 3'd2;
    localparam logic [2:0] SEL_DLO  = 3'd3;
    localparam logic [2:0] SEL_DHI  = 3'd4;

endpackage

// File: rtl/rxmb_pick.sv
// Lowest-index one-hot picker.
// Returns a one-hot grant for the lowest set request bit, plus a flag
// that says whether any bit was set. Purely combinational.
module rxmb_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] grant,
    output logic         any
);
    // Scan from index 0 upwards and keep the first hit.
    always_comb begin
        grant = '0;
        any   = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !any) begin
                grant[i] = 1'b1;
                any      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/rxmb_slot.sv
// One receive mailbox: mode code, stored frame, ready and lost flags.
// Assumes the parent asserts cap only for a mailbox that may accept.
// A capture overrides a re-arm in the same cycle.
module rxmb_slot
    import rxmb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic [2:0] cfg_mode,
    input  logic       cap,
    input  rx_frame_t  frm_in,
    input  logic       rearm,
    output logic [2:0] mode,
    output logic       ready,
    output logic       lost,
    output rx_frame_t  frm_q
);
    // Mode register, written by configuration.
    always_ff @(posedge clk) begin
        if (!rst_n)      mode <= MB_OFF;
        else if (cfg_we) mode <= cfg_mode;
    end

    // Frame storage, loaded on capture.
    always_ff @(posedge clk) begin
        if (!rst_n)   frm_q <= '0;
        else if (cap) frm_q <= frm_in;
    end

    // Ready and lost flags: set by capture, cleared by re-arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready <= 1'b0;
            lost  <= 1'b0;
        end else begin
            ready <= cap | (ready & ~rearm);
            lost  <= (cap & ready) | (lost & ~rearm);
        end
    end
endmodule

// File: rtl/rxmb_bank.sv
// Receive mailbox bank. It steers each decoded frame to the lowest
// enabled empty mailbox. Failing that, it uses the lowest full overwrite
// mailbox; failing both, it drops the frame and sets a sticky overrun.
// Assumes one frame per cycle at most and an accept-all filter.
module rxmb_bank
    import rxmb_pkg::*;
#(
    parameter int NUM_MB = 8,
    localparam int IDXW = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_valid,
    input  logic              frm_ext,
    input  logic [28:0]       frm_id,
    input  logic              frm_rtr,
    input  logic [3:0]        frm_dlc,
    input  logic [63:0]       frm_data,
    input  logic              cfg_we,
    input  logic [IDXW-1:0]   cfg_mb,
    input  logic [2:0]        cfg_mode,
    input  logic              rearm_we,
    input  logic [NUM_MB-1:0] rearm_mask,
    input  logic [NUM_MB-1:0] irq_mask,
    input  logic [IDXW-1:0]   rd_mb,
    input  logic [2:0]        rd_sel,
    output logic [31:0]       rd_data,
    output logic [NUM_MB-1:0] ready_vec,
    output logic              irq,
    output logic              overrun
);
    rx_frame_t          frm_in;
    logic [2:0]         slot_mode [NUM_MB];
    rx_frame_t          slot_frm  [NUM_MB];
    logic [NUM_MB-1:0]  slot_lost;
    logic [NUM_MB-1:0]  free_req, ovr_req, free_gnt, ovr_gnt, cap_vec;
    logic               any_free, any_ovr;

    assign frm_in = '{ext: frm_ext, id: frm_id, rtr: frm_rtr,
                      dlc: frm_dlc, data: frm_data};

    for (genvar i = 0; i < NUM_MB; i++) begin : g_slot
        // Candidate masks for this mailbox.
        always_comb begin
            free_req[i] = (slot_mode[i] == MB_RX || slot_mode[i] == MB_RX_OVR)
                          && !ready_vec[i];
            ovr_req[i]  = (slot_mode[i] == MB_RX_OVR) && ready_vec[i];
        end

        rxmb_slot u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_we   (cfg_we && (cfg_mb == IDXW'(i))),
            .cfg_mode (cfg_mode),
            .cap      (cap_vec[i]),
            .frm_in   (frm_in),
            .rearm    (rearm_we && rearm_mask[i]),
            .mode     (slot_mode[i]),
            .ready    (ready_vec[i]),
            .lost     (slot_lost[i]),
            .frm_q    (slot_frm[i])
        );
    end

    rxmb_pick #(.N(NUM_MB)) u_pick_free (.req(free_req), .grant(free_gnt), .any(any_free));
    rxmb_pick #(.N(NUM_MB)) u_pick_ovr  (.req(ovr_req),  .grant(ovr_gnt),  .any(any_ovr));

    // Capture target: empty mailbox first, then an overwrite mailbox.
    always_comb begin
        cap_vec = '0;
        if (frm_valid) cap_vec = any_free ? free_gnt : ovr_gnt;
    end

    // Sticky overrun when a frame finds no home.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   overrun <= 1'b0;
        else if (frm_valid && !any_free && !any_ovr)  overrun <= 1'b1;
    end

    // Interrupt from masked ready flags.
    assign irq = |(ready_vec & irq_mask);

    // Read-back multiplexer for the selected mailbox and word.
    always_comb begin
        rx_frame_t f;
        f       = slot_frm[rd_mb];
        rd_data = '0;
        if (32'(rd_mb) < NUM_MB) begin
            case (rd_sel)
                SEL_MODE: rd_data = {5'b0, slot_mode[rd_mb], 24'b0};
                SEL_ID:   rd_data = f.ext ? {2'b00, 1'b1, f.id}
                                          : {3'b000, f.id[10:0], 18'b0};
                SEL_STAT: rd_data = {7'b0, slot_lost[rd_mb], ready_vec[rd_mb],
                                     2'b00, f.rtr, f.dlc, 16'b0};
                SEL_DLO:  rd_data = f.data[31:0];
                SEL_DHI:  rd_data = f.data[63:32];
                default:  rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/rxmb_chk.sv
// Checker for the receive mailbox bank, attached by bind.
// Observes ports only.
module rxmb_chk #(
    parameter int NUM_MB = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frm_valid,
    input logic              rearm_we,
    input logic [NUM_MB-1:0] rearm_mask,
    input logic [NUM_MB-1:0] irq_mask,
    input logic [NUM_MB-1:0] ready_vec,
    input logic              irq,
    input logic              overrun
);
    AST_ONE_NEW_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ready_vec & ~$past(ready_vec)) <= 1); // R1

    AST_READY_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        ((ready_vec & ~$past(ready_vec)) != '0) |-> $past(frm_valid)); // R2

    AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rearm_we && !frm_valid) |=> ((ready_vec & $past(rearm_mask)) == '0)); // R3

    AST_IRQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((ready_vec & irq_mask) != '0)); // R8

    AST_OVERRUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R10
endmodule

bind rxmb_bank rxmb_chk #(.NUM_MB(NUM_MB)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_valid  (frm_valid),
    .rearm_we   (rearm_we),
    .rearm_mask (rearm_mask),
    .irq_mask   (irq_mask),
    .ready_vec  (ready_vec),
    .irq        (irq),
    .overrun    (overrun)
);

// File: tb/sim_rxmb_bank.sv
module sim_rxmb_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_MB = 8;
    localparam int IDXW = 3;
    localparam int NT = 7;

    // Table entry: {ext, id[28:0], rtr, dlc[3:0], seed[7:0], expected mailbox[3:0]}
    localparam logic [46:0] TBL [NT] = '{
        {1'b0, 29'h0000_0123, 1'b0, 4'd8,  8'd10, 4'd1},
        {1'b1, 29'h1ABC_DEF0, 1'b0, 4'd4,  8'd20, 4'd2},
        {1'b0, 29'h0000_07FF, 1'b1, 4'd0,  8'd30, 4'd3},
        {1'b1, 29'h0000_0001, 1'b1, 4'd15, 8'd40, 4'd4},
        {1'b0, 29'h0000_0000, 1'b0, 4'd1,  8'd50, 4'd5},
        {1'b0, 29'h0000_0555, 1'b0, 4'd8,  8'd60, 4'd7},
        {1'b1, 29'h1FFF_FFFF, 1'b0, 4'd2,  8'd70, 4'd7}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frm_valid = 1'b0, frm_ext = 1'b0, frm_rtr = 1'b0;
    logic [28:0] frm_id = '0;
    logic [3:0]  frm_dlc = '0;
    logic [63:0] frm_data = '0;
    logic cfg_we = 1'b0;
    logic [IDXW-1:0] cfg_mb = '0;
    logic [2:0] cfg_mode = '0;
    logic rearm_we = 1'b0;
    logic [NUM_MB-1:0] rearm_mask = '0, irq_mask = '0;
    logic [IDXW-1:0] rd_mb = '0;
    logic [2:0] rd_sel = '0;
    logic [31:0] rd_data;
    logic [NUM_MB-1:0] ready_vec;
    logic irq, overrun;

    int nchk = 0;
    int nerr = 0;
    logic [NUM_MB-1:0] occ = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxmb_bank #(.NUM_MB(NUM_MB)) u0 (.*);

    function automatic logic [63:0] mkdata(input logic [7:0] seed);
        logic [63:0] d;
        for (int k = 0; k < 8; k++) d[8*k +: 8] = seed + 8'(k);
        return d;
    endfunction

    function automatic logic [31:0] idword(input logic ext, input logic [28:0] id);
        return ext ? {3'b001, id} : {3'b000, id[10:0], 18'b0};
    endfunction

    function automatic logic [31:0] statword(input logic lost, input logic rdy,
                                             input logic rtr, input logic [3:0] dlc);
        return {7'b0, lost, rdy, 2'b00, rtr, dlc, 16'b0};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input int mb, input logic [2:0] sel, output logic [31:0] v);
        rd_mb = IDXW'(mb);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic set_mode(input int mb, input logic [2:0] m);
        @(negedge clk);
        cfg_we = 1'b1; cfg_mb = IDXW'(mb); cfg_mode = m;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic drive_frame(input logic e, input logic [28:0] id, input logic r,
                               input logic [3:0] dlc, input logic [7:0] seed);
        frm_valid = 1'b1; frm_ext = e; frm_id = id; frm_rtr = r;
        frm_dlc = dlc; frm_data = mkdata(seed);
    endtask

    task automatic send(input logic e, input logic [28:0] id, input logic r,
                        input logic [3:0] dlc, input logic [7:0] seed);
        @(negedge clk);
        drive_frame(e, id, r, dlc, seed);
        @(negedge clk);
        frm_valid = 1'b0;
    endtask

    task automatic rearm(input logic [NUM_MB-1:0] m);
        @(negedge clk);
        rearm_we = 1'b1; rearm_mask = m;
        @(negedge clk);
        rearm_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        // R11: reset state
        check("R11 ready_vec", 32'(ready_vec), 32'h0);
        check("R11 overrun", 32'(overrun), 32'h0);
        check("R11 irq", 32'(irq), 32'h0);
        rst_n = 1'b1;
        rd(1, 3'd0, v); check("R11 mode after reset", v, 32'h0);

        for (int i = 1; i <= 5; i++) set_mode(i, 3'd1);
        set_mode(6, 3'd3);
        set_mode(7, 3'd2);

        // Table walk: R1 R2 R5 R6 R7 R9
        for (int t = 0; t < NT; t++) begin
            logic        e, r, explost;
            logic [28:0] id;
            logic [3:0]  dlc, mb4;
            logic [7:0]  seed;
            logic [63:0] d;
            int mb;
            {e, id, r, dlc, seed, mb4} = TBL[t];
            mb = int'(mb4);
            explost = occ[mb];
            send(e, id, r, dlc, seed);
            occ[mb] = 1'b1;
            d = mkdata(seed);
            check($sformatf("R1 ready_vec after frame %0d", t), 32'(ready_vec), 32'(occ));
            rd(mb, 3'd1, v); check($sformatf("R6 id word frame %0d", t), v, idword(e, id));
            rd(mb, 3'd2, v); check($sformatf("R7 R5 status frame %0d", t), v, statword(explost, 1'b1, r, dlc));
            rd(mb, 3'd3, v); check($sformatf("R9 data low frame %0d", t), v, d[31:0]);
            rd(mb, 3'd4, v); check($sformatf("R9 data high frame %0d", t), v, d[63:32]);
        end

        // R4: disabled and transmit mailboxes stay empty; mode readback
        check("R4 ready_vec skips 0 and 6", 32'(ready_vec), 32'h0000_00BE);
        rd(6, 3'd0, v); check("R4 mode word transmit", v, 32'h0300_0000);
        rd(7, 3'd0, v); check("R4 mode word overwrite", v, 32'h0200_0000);
        check("R10 no overrun while overwrite exists", 32'(overrun), 32'h0);

        // R8: interrupt mask
        irq_mask = 8'h08; #1;
        check("R8 irq masked ready", 32'(irq), 32'h1);
        irq_mask = 8'h41; #1;
        check("R8 irq only empty enabled", 32'(irq), 32'h0);

        // R3: multi-mailbox re-arm clears ready and lost
        rearm(8'h84);
        check("R3 ready after re-arm", 32'(ready_vec), 32'h0000_003A);
        rd(7, 3'd2, v); check("R3 lost and ready cleared", v & 32'h0180_0000, 32'h0);

        // R1: next frame fills the gap at mailbox 2
        send(1'b0, 29'h0AA, 1'b0, 4'd3, 8'd80);
        check("R1 gap refilled", 32'(ready_vec), 32'h0000_003E);
        rd(2, 3'd1, v); check("R1 id in mailbox 2", v, idword(1'b0, 29'h0AA));

        // R5: empty overwrite mailbox takes frame without lost flag
        send(1'b0, 29'h0BB, 1'b1, 4'd6, 8'd90);
        rd(7, 3'd2, v); check("R5 empty overwrite no lost", v, statword(1'b0, 1'b1, 1'b1, 4'd6));

        // R10: no home for frame
        set_mode(7, 3'd1);
        send(1'b0, 29'h0CC, 1'b0, 4'd5, 8'd100);
        check("R10 overrun set", 32'(overrun), 32'h1);
        check("R10 mailboxes unchanged", 32'(ready_vec), 32'h0000_00BE);
        v = 32'h0;
        begin
            logic [63:0] d;
            d = mkdata(8'd90);
            rd(7, 3'd3, v); check("R10 mailbox 7 keeps data", v, d[31:0]);
        end

        rearm(8'h0A);
        check("R3 two bits re-armed", 32'(ready_vec), 32'h0000_00B4);
        check("R10 overrun sticky", 32'(overrun), 32'h1);

        // R12: capture and re-arm of mailbox 1 in one cycle
        @(negedge clk);
        drive_frame(1'b1, 29'h0123_4567, 1'b0, 4'd7, 8'd110);
        rearm_we = 1'b1; rearm_mask = 8'h02;
        @(negedge clk);
        frm_valid = 1'b0; rearm_we = 1'b0;
        check("R12 capture wins", 32'(ready_vec), 32'h0000_00B6);
        rd(1, 3'd1, v); check("R12 id stored", v, idword(1'b1, 29'h0123_4567));

        // R2: full mailbox 1 refused; frame goes to mailbox 3
        send(1'b0, 29'h0DD, 1'b0, 4'd2, 8'd120);
        check("R2 full mailbox skipped", 32'(ready_vec), 32'h0000_00BE);
        rd(1, 3'd1, v); check("R2 mailbox 1 unchanged", v, idword(1'b1, 29'h0123_4567));
        rd(3, 3'd1, v); check("R2 frame in mailbox 3", v, idword(1'b0, 29'h0DD));

        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end
endmodule